// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the control strobes of an asynchronous DRAM interface: one row strobe, a column strobe per byte lane, a write enable and an output enable, all active low. It samples them on a system clock several times faster than the strobe edges. For every period in which the row strobe is low, it works out which kind of memory cycle the controller performed. It also reports which byte lanes were accessed and whether the lanes were driven with conflicting operations.

The access mode opens on the first column strobe to fall, from either lane, and closes only when all column strobes are high again. The write type, however, is judged separately on each lane from that lane's own strobe. A lane whose column strobe never falls in a row cycle is left out, which is how byte-masked access is done. The result is reported once per row cycle as a single-clock pulse after the row strobe returns high. Typical uses are a protocol monitor beside a memory controller, or a trace source for bus analysis.

Top module: `dram_cycle_classifier`

## Requirements
- R1: While reset is held and until the first report, `cycValid` and `skewErr` are 0, `laneTouched` is 0 and `cycCode` is 0 (standby).
- R2: A report is a `cycValid` pulse exactly one clock long. It is seen on the third rising clock edge after the row strobe input rises, because of two synchronizer stages and one edge register. `cycCode` changes only together with `cycValid`.
- R3: If any column strobe is already low when the row strobe falls, the cycle is reported as column-before-row refresh. This holds even when only one lane's strobe is low. The report carries code 6, `laneTouched` = 0 and no error, whatever write enable and output enable do.
- R4: If the row strobe falls with all column strobes high and no column strobe falls before it rises, the cycle is reported as a row-only refresh: code 5 with `laneTouched` = 0.
- R5: A lane whose column strobe falls while write enable stays high is a read: code 1. This holds whether output enable went low or stayed high the whole cycle.
- R6: A lane whose column strobe falls while write enable is already low is an early write: code 2.
- R7: A lane that is not an early write, and sees write enable fall while its column strobe is low without output enable having been low during that access, is a delayed write: code 3.
- R8: A lane that sees write enable fall after output enable was low during the same column access is a read-modify-write: code 4.
- R9: `laneTouched` bit i (bit 0 = lower byte, bit 1 = upper byte) is 1 exactly when lane i's column strobe fell during the cycle. `cycCode` reports the lowest-numbered touched lane. An untouched lane never affects the code or the error.
- R10: When two touched lanes resolve to different codes, `skewErr` pulses together with `cycValid`. It stays 0 when all touched lanes agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rowStbN | input | 1 | Row strobe, active low, asynchronous |
| colStbN | input | NUM_LANES | Column strobe per byte lane, active low, bit 0 = lower byte |
| wrEnN | input | 1 | Write enable, active low |
| outEnN | input | 1 | Output enable, active low |
| cycValid | output | 1 | One-clock pulse marking a classified row cycle |
| cycCode | output | 3 | Cycle type: 0 standby, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh |
| laneTouched | output | NUM_LANES | Lanes whose column strobe fell in the reported cycle |
| skewErr | output | 1 | Pulse with `cycValid` when touched lanes disagree |

## Verification
The hardest case to reach is a row cycle in which the two byte lanes legitimately end up with different write types. Write enable and output enable are shared by both lanes, so each lane's type can only come from the order in which its own strobe moves relative to the shared ones. The stimulus therefore builds every cycle in phases. It opens the early-write lanes first, with write enable low. It then opens and closes the read lanes, then the read-modify-write lanes under a short output-enable window, and finally the delayed-write lanes just before a single write enable fall. This lets a sweep over every pairing of lower-lane operation, upper-lane operation and lane mask produce each conflict and each masked access.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    CYC_STANDBY  = 3'd0,
    CYC_READ     = 3'd1,
    CYC_EARLY_WR = 3'd2,
    CYC_LATE_WR  = 3'd3,
    CYC_RMW      = 3'd4,
    CYC_ROW_REF  = 3'd5,
    CYC_COL_REF  = 3'd6
  } cyc_code_e;

  // Strobes from the control FSM to the lane datapath.
  typedef struct packed {
    logic cycStart;     // row fell with every column strobe high
    logic cbrStart;     // row fell with a column strobe already low
    logic cycEnd;       // row rose, report now
    logic rowCycle;     // inside a normal (non-refresh-by-column) row cycle
    logic cbrCycle;     // inside a column-before-row cycle
    logic accessClose;  // last column strobe rose inside a normal row cycle
  } ctrl_strobe_t;

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rowN,
  input  logic [NUM_LANES-1:0] colN,
  output ctrl_strobe_t         stb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_CBR} ctrl_state_e;

  ctrl_state_e state, stateNext;
  logic rowLow, rowLowPrev, rowFall, rowRise;
  logic anyCol, anyColPrev;

  assign rowLow = ~rowN;
  assign anyCol = |(~colN);
  assign rowFall = rowLow & ~rowLowPrev;
  assign rowRise = ~rowLow & rowLowPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowLowPrev <= 1'b0;
      anyColPrev <= 1'b0;
      state      <= ST_IDLE;
    end else begin
      rowLowPrev <= rowLow;
      anyColPrev <= anyCol;
      state      <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (rowFall) stateNext = anyCol ? ST_CBR : ST_ROW;
      ST_ROW, ST_CBR: if (rowRise) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    stb             = '0;
    stb.cycStart    = (state == ST_IDLE) & rowFall & ~anyCol;
    stb.cbrStart    = (state == ST_IDLE) & rowFall & anyCol;
    stb.cycEnd      = (state != ST_IDLE) & rowRise;
    stb.rowCycle    = (state == ST_ROW);
    stb.cbrCycle    = (state == ST_CBR);
    stb.accessClose = (state == ST_ROW) & ~anyCol & anyColPrev;
  end

endmodule

// File: rtl/dcc_datapath.sv
module dcc_datapath
  import dcc_pkg::*;
#(
  parameter int NUM_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t         stb,
  input  logic [NUM_LANES-1:0] colN,
  input  logic                 wrN,
  input  logic                 oeN,
  output logic                 cycValid,
  output logic [CODE_W-1:0]    cycCode,
  output logic [NUM_LANES-1:0] laneTouched,
  output logic                 skewErr
);

  logic wrLow, wrLowPrev, wrFall, oeLow;
  logic [NUM_LANES-1:0] touchedVec;
  logic [NUM_LANES-1:0][CODE_W-1:0] laneOpVec;

  assign wrLow  = ~wrN;
  assign oeLow  = ~oeN;
  assign wrFall = wrLow & ~wrLowPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrLowPrev <= 1'b0;
    else       wrLowPrev <= wrLow;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic colLow, colLowPrev, laneFall;
    logic touched, earlyWr, lateWr, oeSeen, rmwWr;
    cyc_code_e op;

    assign colLow   = ~colN[g];
    assign laneFall = stb.rowCycle & colLow & ~colLowPrev;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        colLowPrev <= 1'b0;
        touched    <= 1'b0;
        earlyWr    <= 1'b0;
        lateWr     <= 1'b0;
        oeSeen     <= 1'b0;
        rmwWr      <= 1'b0;
      end else begin
        colLowPrev <= colLow;
        if (stb.cycStart || stb.cbrStart) begin
          touched <= 1'b0;
          earlyWr <= 1'b0;
          lateWr  <= 1'b0;
          oeSeen  <= 1'b0;
          rmwWr   <= 1'b0;
        end else if (stb.rowCycle) begin
          if (laneFall) begin
            touched <= 1'b1;
            if (wrLow) earlyWr <= 1'b1;
          end
          if (stb.accessClose) oeSeen <= 1'b0;
          else if (colLow && oeLow) oeSeen <= 1'b1;
          if (wrFall && colLow && !earlyWr && !laneFall) begin
            lateWr <= 1'b1;
            if (oeSeen || oeLow) rmwWr <= 1'b1;
          end
        end
      end
    end

    always_comb begin
      if (earlyWr)     op = CYC_EARLY_WR;
      else if (lateWr) op = rmwWr ? CYC_RMW : CYC_LATE_WR;
      else             op = CYC_READ;
    end

    assign touchedVec[g] = touched;
    assign laneOpVec[g]  = op;
  end

  logic [CODE_W-1:0] pickOp;
  logic found, mismatch;

  always_comb begin
    pickOp = CYC_READ;
    found  = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (touchedVec[i] && !found) begin
        pickOp = laneOpVec[i];
        found  = 1'b1;
      end
    end
    mismatch = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (touchedVec[i] && (laneOpVec[i] != pickOp)) mismatch = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycValid    <= 1'b0;
      cycCode     <= CYC_STANDBY;
      laneTouched <= '0;
      skewErr     <= 1'b0;
    end else begin
      cycValid <= stb.cycEnd;
      skewErr  <= 1'b0;
      if (stb.cycEnd) begin
        if (stb.cbrCycle) begin
          cycCode     <= CYC_COL_REF;
          laneTouched <= '0;
        end else if (!found) begin
          cycCode     <= CYC_ROW_REF;
          laneTouched <= '0;
        end else begin
          cycCode     <= pickOp;
          laneTouched <= touchedVec;
          skewErr     <= mismatch;
        end
      end
    end
  end

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dcc_pkg::*;
#(
  parameter int NUM_LANES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rowStbN,
  input  logic [NUM_LANES-1:0] colStbN,
  input  logic                 wrEnN,
  input  logic                 outEnN,
  output logic                 cycValid,
  output logic [CODE_W-1:0]    cycCode,
  output logic [NUM_LANES-1:0] laneTouched,
  output logic                 skewErr
);

  localparam int SYNC_W = NUM_LANES + 3;

  logic [SYNC_W-1:0] rawBus, syncBus;
  logic rowS, wrS, oeS;
  logic [NUM_LANES-1:0] colS;
  ctrl_strobe_t stb;

  assign rawBus = {rowStbN, wrEnN, outEnN, colStbN};
  assign {rowS, wrS, oeS, colS} = syncBus;

  dcc_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawBus), .syncOut(syncBus)
  );

  dcc_ctrl #(.NUM_LANES(NUM_LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rowN(rowS), .colN(colS), .stb(stb)
  );

  dcc_datapath #(.NUM_LANES(NUM_LANES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .colN(colS), .wrN(wrS), .oeN(oeS),
    .cycValid(cycValid), .cycCode(cycCode), .laneTouched(laneTouched),
    .skewErr(skewErr)
  );

endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int NUM_LANES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cycValid,
  input logic [2:0]           cycCode,
  input logic [NUM_LANES-1:0] laneTouched,
  input logic                 skewErr
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |=> !cycValid); // R2

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cycCode) |-> cycValid); // R2

  AST_NO_STANDBY_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    cycValid |-> (cycCode != 3'd0) && (cycCode != 3'd7)); // R1

  AST_REFRESH_NO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && (cycCode == 3'd5 || cycCode == 3'd6)) |-> (laneTouched == '0) && !skewErr); // R3

  AST_ACCESS_HAS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycCode >= 3'd1 && cycCode <= 3'd4) |-> (laneTouched != '0)); // R9

  AST_SKEW_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rstN)
    skewErr |-> cycValid && ($countones(laneTouched) >= 2)); // R10

endmodule

bind dram_cycle_classifier dcc_checker #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk(clk), .rstN(rstN), .cycValid(cycValid), .cycCode(cycCode),
  .laneTouched(laneTouched), .skewErr(skewErr)
);

// File: tb/dram_cycle_classifier_bench.sv
module dram_cycle_classifier_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowN = 1'b1;
  logic [1:0] colN = 2'b11;
  logic wrN = 1'b1;
  logic oeN = 1'b1;
  logic cycValid, skewErr;
  logic [2:0] cycCode;
  logic [1:0] laneTouched;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dram_cycle_classifier u_dram_cycle_classifier (
    .clk(clk), .rstN(rstN), .rowStbN(rowN), .colStbN(colN), .wrEnN(wrN),
    .outEnN(oeN), .cycValid(cycValid), .cycCode(cycCode),
    .laneTouched(laneTouched), .skewErr(skewErr)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench op: 0 read OE high, 1 read OE low, 2 early, 3 delayed, 4 rmw
  function automatic int opCode(input int op);
    return (op <= 1) ? 1 : op;
  endfunction

  function automatic string opReq(input int code);
    case (code)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic endRow(input int eCode, input int eLanes, input int eErr, input string codeReq);
    rowN = 1'b1;
    tick(1); check(cycValid == 1'b0, "R2", cycValid, 0);
    tick(1); check(cycValid == 1'b0, "R2", cycValid, 0);
    tick(1);
    check(cycValid == 1'b1, "R2", cycValid, 1);
    check(cycCode == 3'(eCode), codeReq, cycCode, eCode);
    check(laneTouched == 2'(eLanes), "R9", laneTouched, eLanes);
    check(skewErr == 1'(eErr), "R10", skewErr, eErr);
    tick(1);
    check(cycValid == 1'b0, "R2", cycValid, 0);
    check(skewErr == 1'b0, "R10", skewErr, 0);
    tick(3);
  endtask

  task automatic accessCycle(input int opLo, input int opHi, input int mask);
    logic [1:0] e, r, m, d;
    logic readOe;
    int eCode, eErr;
    e = '0; r = '0; m = '0; d = '0; readOe = 1'b0;
    for (int i = 0; i < 2; i++) begin
      int op;
      op = (i == 0) ? opLo : opHi;
      if (mask[i]) begin
        case (op)
          0: r[i] = 1'b1;
          1: begin r[i] = 1'b1; readOe = 1'b1; end
          2: e[i] = 1'b1;
          3: d[i] = 1'b1;
          default: m[i] = 1'b1;
        endcase
      end
    end
    rowN = 1'b0; tick(4);
    if (e != 0) begin
      wrN = 1'b0; tick(4); colN = colN & ~e; tick(4); wrN = 1'b1; tick(4);
    end
    if (r != 0) begin
      colN = colN & ~r; tick(4);
      if (readOe) begin oeN = 1'b0; tick(4); oeN = 1'b1; tick(4); end
      colN = colN | r; tick(4);
    end
    if (m != 0) begin
      colN = colN & ~m; tick(4); oeN = 1'b0; tick(4); oeN = 1'b1; tick(4);
    end
    if (d != 0) begin
      colN = colN & ~d; tick(4);
    end
    if ((m | d) != 0) begin
      wrN = 1'b0; tick(4); wrN = 1'b1; tick(4);
    end
    colN = 2'b11; tick(4);
    eCode = mask[0] ? opCode(opLo) : opCode(opHi);
    eErr  = (mask == 3 && opCode(opLo) != opCode(opHi)) ? 1 : 0;
    endRow(eCode, mask, eErr, opReq(eCode));
  endtask

  task automatic cbrCycle(input logic [1:0] lowMask, input logic we, input logic oe);
    colN = ~lowMask; wrN = we; oeN = oe; tick(4);
    rowN = 1'b0; tick(4);
    colN = 2'b11; tick(2);
    colN = ~lowMask; tick(4);
    colN = 2'b11; wrN = 1'b1; oeN = 1'b1; tick(4);
    endRow(6, 0, 0, "R3");
  endtask

  initial begin
    tick(3);
    check(cycValid == 1'b0, "R1", cycValid, 0);
    check(cycCode == 3'd0, "R1", cycCode, 0);
    check(laneTouched == 2'b00, "R1", laneTouched, 0);
    check(skewErr == 1'b0, "R1", skewErr, 0);
    rstN = 1'b1;
    tick(4);
    check(cycValid == 1'b0 && cycCode == 3'd0, "R1", cycCode, 0);

    // R4: row-only refresh, with OE and WE toggling but no column strobe
    rowN = 1'b0; tick(3); oeN = 1'b0; tick(3); oeN = 1'b1; tick(3);
    endRow(5, 0, 0, "R4");
    rowN = 1'b0; tick(3); wrN = 1'b0; tick(3); wrN = 1'b1; tick(3);
    endRow(5, 0, 0, "R4");

    // R3: column-before-row refresh, either or both lanes low first
    for (int lm = 1; lm < 4; lm++) begin
      cbrCycle(2'(lm), 1'b1, 1'b1);
      cbrCycle(2'(lm), 1'b0, 1'b0);
    end

    // R5..R10: sweep lower op x upper op x lane mask
    for (int mask = 1; mask < 4; mask++)
      for (int lo = 0; lo < 5; lo++)
        for (int hi = 0; hi < 5; hi++)
          accessCycle(lo, hi, mask);

    // R4 again after accesses: no stale lane state leaks
    rowN = 1'b0; tick(6);
    endRow(5, 0, 0, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule